// File: doc/BRIEF.md
# Port Overload Fault Timer

This block watches one powered port and decides, on a millisecond time base, whether an overload is serious enough to end the port's power. When the port is first switched on it opens a fixed start window. Across that window it counts the milliseconds in which an overload was present. If overload filled nearly the whole window, the block raises a start fault. Otherwise it raises a power-good event and moves into steady operation.

In steady operation an asymmetric leaky integrator takes over. It climbs quickly while overload is present and drains slowly while it is absent. A sustained overload therefore trips a cut fault, while brief, sparse bursts are absorbed. A protection clamp trip also ends power with a cut fault. A loss of the supply rail ends power silently. The overload flag comes in already computed: it is true when the port current is above its cut level, or when the port voltage has strayed more than 2 V from the negative supply rail. After any fault the block holds a port-off request until the power logic drops the port-on indication. The block then clears all of its counters, ready for a fresh turn-on.

All pins are plain level or single-cycle control signals; there is no data stream and so no valid/ready handshake.

Top module: `port_overload_timer`

## Requirements
- R1: While `rst_n` is low and after its release, `start_fault`, `cut_fault`, `pwr_good` and `port_off` are all 0.
- R2: In the start window (the first START_MS=60 ticks after `port_on` rises), if at least START_MS-SLACK_MS=55 ticks see `overload` high, `start_fault` and `port_off` go high in the cycle after the 60th tick is sampled, and not earlier.
- R3: If fewer than 55 of the 60 window ticks see `overload` high, `pwr_good` pulses in the cycle after the 60th tick, `port_off` stays 0, and the port enters steady operation.
- R4: In steady operation the integrator adds RATIO=16 on each overloaded tick and subtracts 1 on each clean tick, floored at 0 and capped at the trip level CUT_MS*RATIO=960. Reaching the trip level raises `cut_fault` and `port_off` in the cycle after that tick.
- R5: Starting from an empty integrator, continuous overload raises `cut_fault` on the 60th overloaded tick, and not on the 59th.
- R6: One overloaded tick in every 20 never raises `cut_fault`, however long it lasts.
- R7: `clamp_trip` high while the port is in its start window or in steady operation raises `cut_fault` and `port_off` in the next cycle.
- R8: `supply_fault` high while the port is in its start window or in steady operation raises `port_off` in the next cycle, with no `cut_fault`, `start_fault` or `pwr_good`.
- R9: `port_on` low drops `port_off` in the next cycle and clears every counter. A later turn-on starts a full new 60-tick window.
- R10: Once faulted, `port_off` stays high and no event fires until `port_on` falls.
- R11: `overload` is only counted in cycles where `ms_tick` is high. Overload in cycles without a tick has no effect.
- R12: Each event output is a single-cycle pulse, and at most one event fires in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| port_on | input | 1 | High while the port is powered |
| overload | input | 1 | Precomputed overload flag, sampled on ticks |
| supply_fault | input | 1 | Negative supply rail lost |
| clamp_trip | input | 1 | Protection clamp turned on |
| start_fault | output | 1 | Pulse: overload during start window |
| cut_fault | output | 1 | Pulse: sustained overload or clamp trip |
| pwr_good | output | 1 | Pulse: start window passed |
| port_off | output | 1 | Request to remove port power, held until `port_on` falls |

## Verification
The assertions assume that all inputs are synchronous to `clk` and that `ms_tick` is never high for two cycles in a row. They also assume that a faulted port is eventually released by lowering `port_on`. The stimulus changes inputs only on the falling clock edge. It raises `ms_tick` for exactly one cycle per tick, and it presents `clamp_trip` and `supply_fault` only as single-cycle pulses outside tick cycles. Every scenario ends by dropping `port_on` for two cycles, so each turn-on starts from cleared counters.

// File: rtl/pot_pkg.sv
package pot_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_START = 2'd1,
    PH_RUN   = 2'd2,
    PH_FAULT = 2'd3
  } phase_e;
endpackage

// File: rtl/pot_start_window.sv
module pot_start_window #(
  parameter int START_MS = 60,
  parameter int SLACK_MS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic ovl,
  output logic done,
  output logic fail
);
  localparam int EW       = $clog2(START_MS + 1);
  localparam int SW       = EW + 1;
  localparam int FAIL_MIN = START_MS - SLACK_MS;

  logic [EW-1:0] elapsed;
  logic [EW-1:0] ovl_cnt;
  logic [SW-1:0] ovl_sum;

  // the tick being sampled now is included in the verdict
  assign ovl_sum = {1'b0, ovl_cnt} + SW'(ovl);
  assign done    = active && tick && (elapsed == EW'(START_MS - 1));
  assign fail    = (ovl_sum >= SW'(FAIL_MIN));

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      elapsed <= '0;
      ovl_cnt <= '0;
    end else if (tick && (elapsed != EW'(START_MS))) begin
      elapsed <= elapsed + EW'(1);
      if (ovl) ovl_cnt <= ovl_cnt + EW'(1);
    end
  end

  // R2: overloaded ticks can never outnumber elapsed ticks
  a_r2_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    ovl_cnt <= elapsed);
  // R11: the window only advances on a tick
  a_r11_tick_gates_window: assert property (@(posedge clk) disable iff (!rst_n)
    (elapsed > $past(elapsed)) |-> $past(tick));
endmodule

// File: rtl/pot_leaky_integrator.sv
module pot_leaky_integrator #(
  parameter int CUT_MS = 60,
  parameter int RATIO  = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  input  logic ovl,
  output logic trip
);
  localparam int TRIP = CUT_MS * RATIO;
  localparam int AW   = $clog2(TRIP + 1);
  localparam int SW   = AW + 1;

  logic [AW-1:0] acc;
  logic [SW-1:0] up_sum;

  assign up_sum = {1'b0, acc} + SW'(RATIO);
  assign trip   = active && tick && ovl && (up_sum >= SW'(TRIP));

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      acc <= '0;
    end else if (tick) begin
      if (ovl) begin
        acc <= (up_sum >= SW'(TRIP)) ? AW'(TRIP) : up_sum[AW-1:0];
      end else if (acc != '0) begin
        acc <= acc - AW'(1);
      end
    end
  end

  // R4: level never passes the trip ceiling
  a_r4_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
    acc <= AW'(TRIP));
  // R4: a rise only follows an overloaded tick
  a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (acc > $past(acc)) |-> $past(tick && ovl));
  // R11: a fall only follows a clean tick or a clear
  a_r11_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (acc < $past(acc)) |-> ($past(tick && !ovl) || $past(!active)));
endmodule

// File: rtl/port_overload_timer.sv
module port_overload_timer #(
  parameter int START_MS = 60,
  parameter int SLACK_MS = 5,
  parameter int CUT_MS   = 60,
  parameter int RATIO    = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic port_on,
  input  logic overload,
  input  logic supply_fault,
  input  logic clamp_trip,
  output logic start_fault,
  output logic cut_fault,
  output logic pwr_good,
  output logic port_off
);
  import pot_pkg::*;

  phase_e phase, phase_nxt;
  logic   win_active, int_active;
  logic   win_done, win_fail, int_trip;
  logic   s_nxt, c_nxt, g_nxt;

  assign win_active = port_on && (phase == PH_START);
  assign int_active = port_on && (phase == PH_RUN);

  pot_start_window #(.START_MS(START_MS), .SLACK_MS(SLACK_MS)) u_win (
    .clk(clk), .rst_n(rst_n), .active(win_active), .tick(ms_tick),
    .ovl(overload), .done(win_done), .fail(win_fail)
  );

  pot_leaky_integrator #(.CUT_MS(CUT_MS), .RATIO(RATIO)) u_int (
    .clk(clk), .rst_n(rst_n), .active(int_active), .tick(ms_tick),
    .ovl(overload), .trip(int_trip)
  );

  always_comb begin
    phase_nxt = phase;
    s_nxt     = 1'b0;
    c_nxt     = 1'b0;
    g_nxt     = 1'b0;
    if (!port_on) begin
      phase_nxt = PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE:  phase_nxt = PH_START;
        PH_START, PH_RUN: begin
          if (supply_fault) begin
            phase_nxt = PH_FAULT;
          end else if (clamp_trip) begin
            c_nxt     = 1'b1;
            phase_nxt = PH_FAULT;
          end else if (win_done) begin
            if (win_fail) begin
              s_nxt     = 1'b1;
              phase_nxt = PH_FAULT;
            end else begin
              g_nxt     = 1'b1;
              phase_nxt = PH_RUN;
            end
          end else if (int_trip) begin
            c_nxt     = 1'b1;
            phase_nxt = PH_FAULT;
          end
        end
        PH_FAULT: phase_nxt = PH_FAULT;
        default:  phase_nxt = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase       <= PH_IDLE;
      start_fault <= 1'b0;
      cut_fault   <= 1'b0;
      pwr_good    <= 1'b0;
      port_off    <= 1'b0;
    end else begin
      phase       <= phase_nxt;
      start_fault <= s_nxt;
      cut_fault   <= c_nxt;
      pwr_good    <= g_nxt;
      port_off    <= (phase_nxt == PH_FAULT);
    end
  end

  // R12: events are exclusive single-cycle pulses
  a_r12_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_fault, cut_fault, pwr_good}));
  a_r12_cut_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cut_fault |=> !cut_fault);
  a_r12_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_fault |=> !start_fault);
  // R7: clamp trip ends power with a cut event
  a_r7_clamp_cut: assert property (@(posedge clk) disable iff (!rst_n)
    (port_on && clamp_trip && !supply_fault && (phase == PH_START || phase == PH_RUN))
      |=> (cut_fault && port_off));
  // R8: supply loss turns off silently
  a_r8_supply_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (port_on && supply_fault && (phase == PH_START || phase == PH_RUN))
      |=> (port_off && !cut_fault && !start_fault && !pwr_good));
  // R9: dropping port_on releases the off request
  a_r9_release: assert property (@(posedge clk) disable iff (!rst_n)
    !port_on |=> !port_off);
  // R10: a faulted port stays off and quiet
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (port_on && phase == PH_FAULT)
      |=> (port_off && !cut_fault && !start_fault && !pwr_good));
endmodule

// File: tb/test_port_overload_timer.sv
module test_port_overload_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, port_on = 1'b0, overload = 1'b0;
  logic supply_fault = 1'b0, clamp_trip = 1'b0;
  logic start_fault, cut_fault, pwr_good, port_off;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit seen_s, seen_c, seen_g;

  always #5 clk = ~clk;

  port_overload_timer i_port_overload_timer (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .port_on(port_on),
    .overload(overload), .supply_fault(supply_fault), .clamp_trip(clamp_trip),
    .start_fault(start_fault), .cut_fault(cut_fault), .pwr_good(pwr_good),
    .port_off(port_off)
  );

  // window vectors: overloaded ticks at the start of the window, expected start fault
  localparam int NV = 6;
  localparam int VEC_N [NV] = '{0, 30, 54, 55, 58, 60};
  localparam bit VEC_F [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1};

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clr_seen();
    seen_s = 0; seen_c = 0; seen_g = 0;
  endtask

  task automatic tk(input logic ov);
    ms_tick = 1'b1; overload = ov;
    @(negedge clk);
    ms_tick = 1'b0; overload = 1'b0;
    seen_s |= start_fault; seen_c |= cut_fault; seen_g |= pwr_good;
  endtask

  task automatic idle(input int k, input logic ov);
    for (int i = 0; i < k; i++) begin
      overload = ov;
      @(negedge clk);
      seen_s |= start_fault; seen_c |= cut_fault; seen_g |= pwr_good;
    end
    overload = 1'b0;
  endtask

  task automatic power_on();
    port_on = 1'b1;
    @(negedge clk);
    clr_seen();
  endtask

  task automatic power_off();
    port_on = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic to_run();
    power_on();
    for (int i = 0; i < 60; i++) tk(1'b0);
    clr_seen();
  endtask

  initial begin
    #2_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    // R1 reset
    repeat (3) @(negedge clk);
    chk({start_fault, cut_fault, pwr_good, port_off} == 4'b0, "R1 in reset",
        {start_fault, cut_fault, pwr_good, port_off}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({start_fault, cut_fault, pwr_good, port_off} == 4'b0, "R1 after reset",
        {start_fault, cut_fault, pwr_good, port_off}, 0);

    // R2 / R3 start window vectors
    for (int v = 0; v < NV; v++) begin
      power_on();
      for (int i = 0; i < 59; i++) tk(i < VEC_N[v]);
      chk(!(seen_s || seen_g || port_off), "R2 no early verdict", seen_s | seen_g, 0);
      tk(59 < VEC_N[v]);
      chk(start_fault == VEC_F[v], "R2 start_fault", start_fault, VEC_F[v]);
      chk(pwr_good == !VEC_F[v], "R3 pwr_good", pwr_good, !VEC_F[v]);
      chk(port_off == VEC_F[v], "R2 port_off", port_off, VEC_F[v]);
      @(negedge clk);
      chk(!start_fault && !pwr_good, "R12 single pulse", start_fault | pwr_good, 0);
      power_off();
    end

    // R11 overload between ticks is ignored
    power_on();
    for (int i = 0; i < 60; i++) begin
      tk(1'b0);
      if (i < 59) idle(3, 1'b1);
    end
    chk(seen_g && !seen_s, "R11 off-tick overload ignored", seen_s, 0);
    power_off();

    // R5 continuous overload trips on the 60th tick
    to_run();
    for (int i = 0; i < 59; i++) tk(1'b1);
    chk(!seen_c && !port_off, "R5 no cut at 59", seen_c, 0);
    tk(1'b1);
    chk(cut_fault && port_off, "R5 cut at 60", cut_fault, 1);
    // R10 faulted port holds off, no more events
    clr_seen();
    for (int i = 0; i < 70; i++) tk(1'b1);
    chk(port_off && !seen_c && !seen_s && !seen_g, "R10 hold quiet", seen_c, 0);
    power_off();
    chk(!port_off, "R9 release", port_off, 0);

    // R4 decay at one sixteenth: 30 up, 160 down, then 40 more needed
    to_run();
    for (int i = 0; i < 30; i++) tk(1'b1);
    for (int i = 0; i < 160; i++) tk(1'b0);
    for (int i = 0; i < 39; i++) tk(1'b1);
    chk(!seen_c, "R4 no cut before level", seen_c, 0);
    tk(1'b1);
    chk(cut_fault && port_off, "R4 cut at level", cut_fault, 1);
    power_off();

    // R4 floor at zero: long clean run then 60 still needed
    to_run();
    for (int i = 0; i < 200; i++) tk(1'b0);
    for (int i = 0; i < 59; i++) tk(1'b1);
    chk(!seen_c, "R4 floor holds", seen_c, 0);
    tk(1'b1);
    chk(cut_fault, "R4 cut after floor", cut_fault, 1);
    power_off();

    // R6 low duty never trips
    to_run();
    for (int i = 0; i < 2000; i++) tk(i % 20 == 0);
    chk(!seen_c && !port_off, "R6 low duty", seen_c, 0);
    power_off();

    // R7 clamp in start window
    power_on();
    for (int i = 0; i < 5; i++) tk(1'b0);
    clamp_trip = 1'b1;
    @(negedge clk);
    clamp_trip = 1'b0;
    chk(cut_fault && port_off, "R7 clamp in window", cut_fault, 1);
    clr_seen();
    for (int i = 0; i < 60; i++) tk(1'b0);
    chk(!seen_g && port_off, "R10 no pwr_good after clamp", seen_g, 0);
    power_off();

    // R7 clamp in steady operation
    to_run();
    clamp_trip = 1'b1;
    @(negedge clk);
    clamp_trip = 1'b0;
    chk(cut_fault && port_off, "R7 clamp in run", cut_fault, 1);
    power_off();

    // R8 supply loss silent
    to_run();
    supply_fault = 1'b1;
    @(negedge clk);
    supply_fault = 1'b0;
    chk(port_off && !cut_fault && !start_fault && !pwr_good, "R8 silent off",
        cut_fault, 0);
    power_off();

    // R9 repower starts a fresh full window after a fault
    power_on();
    for (int i = 0; i < 59; i++) tk(1'b0);
    chk(!seen_g && !port_off, "R9 fresh window", seen_g, 0);
    tk(1'b0);
    chk(pwr_good, "R9 pwr_good at 60", pwr_good, 1);
    power_off();

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule